// File: doc/BRIEF.md
# Receive Error Status with Break-Guarded Clearing

This block keeps the sticky error flags of a serial receiver: parity, framing, noise and overrun. Each flag is set by a one-cycle report pulse from the receiver and stays set until software clears it. Any set flag whose own enable is high raises one shared error interrupt request. The receive datapath, the baud timing and any line encoding live elsewhere. The block sees only the pulses and the bus strobes.

Clearing takes two steps. First, a read of the status register arms every flag that is set at that moment. Later, an access to the receive data register clears the armed flags. A debug-break input can freeze this sequence. While break is active and the break-clear-enable input is low, status reads and data accesses leave both the flags and the armed state untouched. A first step taken before the break therefore survives the break and can be completed after it. When break-clear-enable is high, clearing works normally during break, and flags cleared there stay cleared.

The status and data strobes are plain one-cycle qualifiers from the register decoder. There is no data stream, so no valid/ready handshake is used and no back-pressure applies.

Top module: `rxerr_status`

## Requirements
- R1: After reset all flags are 0, the interrupt request is 0 and no flag is armed. A data access straight after reset clears nothing.
- R2: Flag bit order is [0] parity, [1] framing, [2] noise, [3] overrun. When the receiver is enabled, a pulse on `err_ev[i]` sets `flags[i]` on the next clock edge.
- R3: While `rx_en` is 0, error pulses are ignored and no flag becomes set.
- R4: `err_irq` is 1 exactly when some `flags[i]` and `irq_en[i]` are both 1.
- R5: A `stat_rd` arms the flags set in that cycle. A later `data_acc` clears only those armed flags, one edge later, and disarms everything. Flags set after the read remain.
- R6: A `data_acc` with nothing armed changes no flag. A `stat_rd` while no flag is set arms nothing.
- R7: An error pulse arriving in the same cycle as the clearing access keeps that flag set.
- R8: While `brk_active` is 1 and `brk_clr_en` is 0, `stat_rd` and `data_acc` change neither the flags nor the armed state.
- R9: While `brk_active` is 1 and `brk_clr_en` is 1, a complete read-then-access sequence clears the armed flags.
- R10: Arming done before a break with `brk_clr_en` at 0 is kept through the break. A `data_acc` after the break then clears those flags.
- R11: A flag cleared during break stays 0 after break ends unless a new error pulse arrives.
- R12: When `stat_rd` and `data_acc` occur in the same cycle, the access clears the previously armed flags and the read is ignored, so nothing is armed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; gates error pulses |
| err_ev | input | 4 | One-cycle error pulses: [0] parity, [1] framing, [2] noise, [3] overrun |
| irq_en | input | 4 | Per-flag interrupt enables, same bit order |
| brk_active | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Allows clearing while break is active |
| stat_rd | input | 1 | Status register read strobe (first clear step) |
| data_acc | input | 1 | Data register access strobe (second clear step) |
| flags | output | 4 | Sticky error flags, same bit order |
| err_irq | output | 1 | Combined error interrupt request |

## Verification
The armed state has no output of its own. A wrong arm bit shows only when a later `data_acc` clears a flag it should have spared, or spares one it should have cleared. That error is visible on `flags` and `err_irq` one edge after the access, which may be many cycles after the fault. The bench therefore tracks an armed-state model and checks both outputs after every cycle. Directed sequences place a break between the two steps, overlap the strobes, and collide pulses with accesses so that such hidden faults surface quickly.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int unsigned RXERR_NFLAG = 4;
  typedef enum int unsigned {
    FL_PARITY  = 0,
    FL_FRAMING = 1,
    FL_NOISE   = 2,
    FL_OVERRUN = 3
  } rxerr_idx_e;
endpackage

// File: rtl/rxerr_gate.sv
module rxerr_gate (
  input  logic brk_active,
  input  logic brk_clr_en,
  input  logic stat_rd,
  input  logic data_acc,
  output logic rd_take,
  output logic acc_take
);
  logic clr_allowed;
  // clearing is frozen during break unless explicitly permitted
  assign clr_allowed = !brk_active || brk_clr_en;
  // the access step has priority over a same-cycle read
  assign acc_take = data_acc && clr_allowed;
  assign rd_take  = stat_rd && clr_allowed && !data_acc;
endmodule

// File: rtl/rxerr_bit.sv
module rxerr_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic rx_en,
  input  logic rd_take,
  input  logic acc_take,
  output logic flag_q
);
  logic arm_q;
  logic set_now;

  assign set_now = ev && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // a new event wins over a clear in the same cycle
      if (set_now)
        flag_q <= 1'b1;
      else if (acc_take && arm_q)
        flag_q <= 1'b0;

      if (acc_take)
        arm_q <= 1'b0;
      else if (rd_take)
        arm_q <= flag_q;
    end
  end
endmodule

// File: rtl/rxerr_irq.sv
module rxerr_irq #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] irq_en,
  output logic         irq
);
  logic [N:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign chain[i+1] = chain[i] | (flags[i] & irq_en[i]);
  end
  assign irq = chain[N];
endmodule

// File: rtl/rxerr_status.sv
module rxerr_status #(
  parameter int unsigned NFLAG = rxerr_pkg::RXERR_NFLAG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [NFLAG-1:0] err_ev,
  input  logic [NFLAG-1:0] irq_en,
  input  logic             brk_active,
  input  logic             brk_clr_en,
  input  logic             stat_rd,
  input  logic             data_acc,
  output logic [NFLAG-1:0] flags,
  output logic             err_irq
);
  logic rd_take;
  logic acc_take;

  rxerr_gate u_gate (
    .brk_active (brk_active),
    .brk_clr_en (brk_clr_en),
    .stat_rd    (stat_rd),
    .data_acc   (data_acc),
    .rd_take    (rd_take),
    .acc_take   (acc_take)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    rxerr_bit u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (err_ev[i]),
      .rx_en    (rx_en),
      .rd_take  (rd_take),
      .acc_take (acc_take),
      .flag_q   (flags[i])
    );
  end

  rxerr_irq #(.N(NFLAG)) u_irq (
    .flags  (flags),
    .irq_en (irq_en),
    .irq    (err_irq)
  );
endmodule

// File: rtl/rxerr_status_chk.sv
module rxerr_status_chk #(
  parameter int unsigned NFLAG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic [NFLAG-1:0] err_ev,
  input logic [NFLAG-1:0] irq_en,
  input logic             brk_active,
  input logic             brk_clr_en,
  input logic             data_acc,
  input logic [NFLAG-1:0] flags,
  input logic             err_irq
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> ((flags & $past(err_ev)) == $past(err_ev)));

  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> ((flags & ~$past(flags)) == '0));

  p_irq_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & irq_en) != '0) |-> err_irq);

  p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & irq_en) == '0) |-> !err_irq);

  p_fall_needs_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_acc |=> ((~flags & $past(flags)) == '0));

  p_break_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && !brk_clr_en) |=> ((~flags & $past(flags)) == '0));
endmodule

bind rxerr_status rxerr_status_chk #(.NFLAG(NFLAG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .err_ev     (err_ev),
  .irq_en     (irq_en),
  .brk_active (brk_active),
  .brk_clr_en (brk_clr_en),
  .data_acc   (data_acc),
  .flags      (flags),
  .err_irq    (err_irq)
);

// File: tb/sim_rxerr_status.sv
module sim_rxerr_status;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic [N-1:0] err_ev = '0;
  logic [N-1:0] irq_en = '0;
  logic brk_active = 1'b0;
  logic brk_clr_en = 1'b0;
  logic stat_rd = 1'b0;
  logic data_acc = 1'b0;
  logic [N-1:0] flags;
  logic err_irq;

  int total = 0;
  int bad = 0;
  logic [N-1:0] m_flags = '0;
  logic [N-1:0] m_arm = '0;

  always #5 clk = ~clk;

  rxerr_status u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .err_ev(err_ev), .irq_en(irq_en),
    .brk_active(brk_active), .brk_clr_en(brk_clr_en), .stat_rd(stat_rd),
    .data_acc(data_acc), .flags(flags), .err_irq(err_irq)
  );

  function automatic logic [N-1:0] f_next_flags(logic [N-1:0] fl, logic [N-1:0] arm,
      logic [N-1:0] ev, logic en, logic acc, logic brk, logic cen);
    logic ok;
    logic [N-1:0] clr;
    ok  = !brk || cen;
    clr = (acc && ok) ? arm : '0;
    return (fl & ~clr) | (en ? ev : '0);
  endfunction

  function automatic logic [N-1:0] f_next_arm(logic [N-1:0] fl, logic [N-1:0] arm,
      logic rd, logic acc, logic brk, logic cen);
    logic ok;
    ok = !brk || cen;
    if (acc && ok) return '0;
    if (rd && ok) return fl;
    return arm;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one clock: model follows the inputs set before the edge, outputs checked after it
  task automatic step(string tag);
    logic [N-1:0] nf;
    logic [N-1:0] na;
    @(posedge clk);
    nf = f_next_flags(m_flags, m_arm, err_ev, rx_en, data_acc, brk_active, brk_clr_en);
    na = f_next_arm(m_flags, m_arm, stat_rd, data_acc, brk_active, brk_clr_en);
    m_flags = nf;
    m_arm = na;
    #1;
    chk(tag, flags, m_flags);
    chk("R4", {3'b0, err_irq}, {3'b0, |(m_flags & irq_en)});
    @(negedge clk);
    err_ev = '0; stat_rd = 1'b0; data_acc = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", flags, 4'b0000);
    chk("R1", {3'b0, err_irq}, 4'b0000);
    rst_n = 1'b1;
    rx_en = 1'b1;
    irq_en = 4'b1111;
    data_acc = 1'b1; step("R1");
    err_ev = 4'b0001; step("R2");
    chk("R2", flags, 4'b0001);
    data_acc = 1'b1; step("R1");
    chk("R1", flags, 4'b0001);
    rx_en = 1'b0; err_ev = 4'b0010; step("R3");
    chk("R3", flags, 4'b0001);
    rx_en = 1'b1;
    irq_en = 4'b1110; step("R4");
    chk("R4", {3'b0, err_irq}, 4'b0000);
    irq_en = 4'b0001; step("R4");
    chk("R4", {3'b0, err_irq}, 4'b0001);
    // two-step clear spares a flag set after the read
    stat_rd = 1'b1; step("R5");
    err_ev = 4'b0100; step("R5");
    data_acc = 1'b1; step("R5");
    chk("R5", flags, 4'b0100);
    data_acc = 1'b1; step("R6");
    chk("R6", flags, 4'b0100);
    // pulse collides with clearing access
    stat_rd = 1'b1; step("R7");
    data_acc = 1'b1; err_ev = 4'b0100; step("R7");
    chk("R7", flags, 4'b0100);
    // same-cycle read and access
    stat_rd = 1'b1; step("R12");
    stat_rd = 1'b1; data_acc = 1'b1; step("R12");
    chk("R12", flags, 4'b0000);
    err_ev = 4'b0010; step("R12");
    data_acc = 1'b1; step("R12");
    chk("R12", flags, 4'b0010);
    // frozen break
    brk_active = 1'b1;
    stat_rd = 1'b1; step("R8");
    data_acc = 1'b1; step("R8");
    chk("R8", flags, 4'b0010);
    brk_active = 1'b0;
    data_acc = 1'b1; step("R8");
    chk("R8", flags, 4'b0010);
    // arming before break survives it
    stat_rd = 1'b1; step("R10");
    brk_active = 1'b1;
    data_acc = 1'b1; step("R10");
    chk("R10", flags, 4'b0010);
    brk_active = 1'b0;
    data_acc = 1'b1; step("R10");
    chk("R10", flags, 4'b0000);
    // clearing permitted during break
    err_ev = 4'b1000; step("R9");
    brk_active = 1'b1; brk_clr_en = 1'b1;
    stat_rd = 1'b1; step("R9");
    data_acc = 1'b1; step("R9");
    chk("R9", flags, 4'b0000);
    brk_active = 1'b0; brk_clr_en = 1'b0;
    repeat (3) step("R11");
    chk("R11", flags, 4'b0000);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      rx_en      = ($urandom % 8) != 0;
      err_ev     = (($urandom % 4) == 0) ? N'($urandom) : '0;
      irq_en     = N'($urandom);
      brk_active = ($urandom % 4) == 0;
      brk_clr_en = ($urandom % 2) == 0;
      stat_rd    = ($urandom % 3) == 0;
      data_acc   = ($urandom % 3) == 0;
      step("R5");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule